// File: doc/BRIEF.md
# Flash Command Buffer Status Controller

This block keeps the status byte of a flash command controller. The controller can hold two commands at once: one running in the flash-operation engine, and one waiting in a single-entry buffer. Software opens a write sequence by writing an aligned word to the flash space. It commits the sequence by writing 1 to the buffer-empty flag, or abandons it by writing 0 there. The block hands buffered commands to the engine through a start strobe and a done strobe. It records the engine's blank and fail results, and gathers error reports from the protection and sequence checkers.

A mode input picks normal or special operation. In special mode the fail and done results become visible, and a pending fail result blocks a new write sequence. Two interrupt outputs follow the buffer-empty and command-complete flags, each gated by its own enable bit in a small configuration register.

Top module: `flash_cmd_stat`

## Requirements
- R1: After a synchronous reset, the status register reads 0xC0, the configuration register reads 0x00, and both interrupt outputs are 0. Status bits, from bit 7 down to bit 0, are: buffer-empty, command-complete, protection violation, access error, reserved (reads 0), blank, fail, done. The status register is at address 0 and the configuration register at address 1. Read data is registered, so it shows the state one clock after the address is applied.
- R2: A pulse on `flash_wr` while buffer-empty is 1 opens a write sequence. Writing 1 to status bit 7 during that sequence clears buffer-empty and commits the command. If the engine is idle, `eng_start` pulses for exactly one cycle on the following clock, and buffer-empty returns to 1.
- R3: Writing 0 to status bit 7 while a write sequence is open aborts the sequence and sets the access-error flag (bit 4). A later write of 1 to bit 7 then starts no command.
- R4: Writing 0 to status bit 7 while no write sequence is open has no effect and leaves the access-error flag clear.
- R5: Command-complete (bit 6) is 1 only while buffer-empty is 1 and the engine is idle. When the engine finishes while a command is buffered, that command starts at once (`eng_start` pulses) and command-complete stays 0.
- R6: Writes to the command-complete and blank bits (bits 6 and 2) are ignored.
- R7: The protection-violation flag (bit 5) and the access-error flag (bit 4) are set by `prot_viol_in` and `acc_err_in` and cleared by writing 1 to their bits. If a set and a clear fall in the same cycle, the set wins.
- R8: In normal mode the fail and done bits (bits 1 and 0) read as 0, and writes to them are ignored.
- R9: In special mode the fail bit is visible and is cleared by writing 1 to bit 1. The done bit is read-only. A `flash_wr` while fail is set opens no sequence and sets access error.
- R10: `irq_buf` is configuration bit 7 AND buffer-empty, and `irq_cmp` is configuration bit 6 AND command-complete. Both are registered, one cycle behind the flags.
- R11: When the engine reports `eng_done`, the block captures `eng_blank` into blank, sets done, and sets fail if `eng_fail` is 1. A command start that coincides with no completion clears blank and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 selects special mode, 0 selects normal mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register select: 0 is status, 1 is configuration |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for the selected register |
| flash_wr | input | 1 | Aligned word written to the flash space |
| prot_viol_in | input | 1 | Set request for the protection-violation flag |
| acc_err_in | input | 1 | Set request for the access-error flag |
| eng_start | output | 1 | One-cycle pulse that hands a command to the engine |
| eng_done | input | 1 | Engine finished the active command |
| eng_blank | input | 1 | Blank result, valid with eng_done |
| eng_fail | input | 1 | Fail result, valid with eng_done |
| irq_buf | output | 1 | Buffer-empty interrupt request |
| irq_cmp | output | 1 | Command-complete interrupt request |

## Verification
Two pairs of events can meet in one clock. The first pair is a hardware set and a software write-1 clear on the same error flag. The bench provokes this on purpose, and it also lets it happen in a seeded random phase. It judges the result against a bench model in which the set wins. The second pair is an engine completion and the promotion of a buffered command. The bench commits a second command while the first is still running, then raises `eng_done`. It then checks that `eng_start` pulses again in the same cycle and that command-complete stays low until the final completion.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  // status bit positions (order is the register layout)
  localparam int S_BUF   = 7;
  localparam int S_CMP   = 6;
  localparam int S_PV    = 5;
  localparam int S_AE    = 4;
  localparam int S_BLANK = 2;
  localparam int S_FAIL  = 1;
  localparam int S_DONE  = 0;
  // configuration bit positions
  localparam int C_BUFIE = 7;
  localparam int C_CMPIE = 6;

  typedef struct packed {
    logic pv;
    logic ae;
    logic blank;
    logic fail;
    logic done;
  } err_flags_t;
endpackage

// File: rtl/fcs_cmd_pipe.sv
module fcs_cmd_pipe (
  input  logic clk,
  input  logic rst,
  input  logic special_mode,
  input  logic fail_flag,
  input  logic flash_wr,
  input  logic stat_wr,
  input  logic buf_wbit,
  input  logic eng_done,
  output logic buf_empty,
  output logic cmd_idle,
  output logic eng_start,
  output logic start_now,
  output logic seq_err
);
  logic seq_q, busy_q, cbeif_q, ccif_q, start_q;
  logic seq_begin, fail_block, launch, abort_seq;
  logic cbeif_d, busy_d, seq_d;

  assign fail_block = flash_wr & cbeif_q & ~seq_q & special_mode & fail_flag;
  assign seq_begin  = flash_wr & cbeif_q & ~seq_q & ~(special_mode & fail_flag);
  assign launch     = stat_wr & buf_wbit & seq_q & cbeif_q;
  assign abort_seq  = stat_wr & ~buf_wbit & seq_q;
  assign seq_err    = abort_seq | fail_block;

  // buffered command moves to the engine when it is free or just finishing
  assign start_now  = ~cbeif_q & (~busy_q | eng_done);

  always_comb begin
    cbeif_d = cbeif_q;
    if (start_now)   cbeif_d = 1'b1;
    else if (launch) cbeif_d = 1'b0;
    busy_d = start_now | (busy_q & ~eng_done);
    seq_d  = seq_q;
    if (launch | abort_seq) seq_d = 1'b0;
    else if (seq_begin)     seq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= 1'b0;
      busy_q  <= 1'b0;
      cbeif_q <= 1'b1;
      ccif_q  <= 1'b1;
      start_q <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      busy_q  <= busy_d;
      cbeif_q <= cbeif_d;
      ccif_q  <= cbeif_d & ~busy_d;
      start_q <= start_now;
    end
  end

  assign buf_empty = cbeif_q;
  assign cmd_idle  = ccif_q;
  assign eng_start = start_q;

  assert_cmp_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
    ccif_q |-> (cbeif_q && !busy_q));
  assert_no_restart_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !eng_done) |=> !start_q);
  assert_abort_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !buf_wbit && seq_q) |=> (!seq_q && cbeif_q));
endmodule

// File: rtl/fcs_flag_bank.sv
module fcs_flag_bank
  import fcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          special_mode,
  input  logic          stat_wr,
  input  logic [DW-1:0] wdata,
  input  logic          pv_set,
  input  logic          ae_set,
  input  logic          seq_err,
  input  logic          start_now,
  input  logic          eng_done,
  input  logic          eng_blank,
  input  logic          eng_fail,
  output err_flags_t    flags
);
  err_flags_t q, d;
  logic pv_clr, ae_clr, fail_clr;

  assign pv_clr   = stat_wr & wdata[S_PV];
  assign ae_clr   = stat_wr & wdata[S_AE];
  assign fail_clr = stat_wr & wdata[S_FAIL] & special_mode;

  always_comb begin
    d.pv   = pv_set | (q.pv & ~pv_clr);
    d.ae   = ae_set | seq_err | (q.ae & ~ae_clr);
    d.fail = (eng_done & eng_fail) | (q.fail & ~fail_clr);
    if (eng_done) begin
      d.blank = eng_blank;
      d.done  = 1'b1;
    end else if (start_now) begin
      d.blank = 1'b0;
      d.done  = 1'b0;
    end else begin
      d.blank = q.blank;
      d.done  = q.done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  assign flags = q;

  assert_w1c_pv_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata[S_PV] && !pv_set) |=> !q.pv);
  assert_set_wins_pv_R7: assert property (@(posedge clk) disable iff (rst)
    pv_set |=> q.pv);
  assert_set_wins_ae_R7: assert property (@(posedge clk) disable iff (rst)
    (ae_set || seq_err) |=> q.ae);
endmodule

// File: rtl/flash_cmd_stat.sv
module flash_cmd_stat
  import fcs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          special_mode,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          flash_wr,
  input  logic          prot_viol_in,
  input  logic          acc_err_in,
  output logic          eng_start,
  input  logic          eng_done,
  input  logic          eng_blank,
  input  logic          eng_fail,
  output logic          irq_buf,
  output logic          irq_cmp
);
  localparam logic [AW-1:0] ADDR_STAT = AW'(0);
  localparam logic [AW-1:0] ADDR_CFG  = AW'(1);

  logic       stat_wr, cfg_wr;
  logic       buf_empty, cmd_idle, start_now, seq_err;
  err_flags_t flags;
  logic       bufie_q, cmpie_q;
  logic [DW-1:0] stat_view, cfg_view, rdata_q;
  logic       irq_buf_q, irq_cmp_q;

  assign stat_wr = reg_wr & (reg_addr == ADDR_STAT);
  assign cfg_wr  = reg_wr & (reg_addr == ADDR_CFG);

  fcs_cmd_pipe u_pipe (
    .clk(clk), .rst(rst), .special_mode(special_mode), .fail_flag(flags.fail),
    .flash_wr(flash_wr), .stat_wr(stat_wr), .buf_wbit(reg_wdata[S_BUF]),
    .eng_done(eng_done), .buf_empty(buf_empty), .cmd_idle(cmd_idle),
    .eng_start(eng_start), .start_now(start_now), .seq_err(seq_err)
  );

  fcs_flag_bank #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .special_mode(special_mode), .stat_wr(stat_wr),
    .wdata(reg_wdata), .pv_set(prot_viol_in), .ae_set(acc_err_in),
    .seq_err(seq_err), .start_now(start_now), .eng_done(eng_done),
    .eng_blank(eng_blank), .eng_fail(eng_fail), .flags(flags)
  );

  always_comb begin
    stat_view          = '0;
    stat_view[S_BUF]   = buf_empty;
    stat_view[S_CMP]   = cmd_idle;
    stat_view[S_PV]    = flags.pv;
    stat_view[S_AE]    = flags.ae;
    stat_view[S_BLANK] = flags.blank;
    stat_view[S_FAIL]  = special_mode & flags.fail;
    stat_view[S_DONE]  = special_mode & flags.done;
    cfg_view           = '0;
    cfg_view[C_BUFIE]  = bufie_q;
    cfg_view[C_CMPIE]  = cmpie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufie_q   <= 1'b0;
      cmpie_q   <= 1'b0;
      rdata_q   <= '0;
      irq_buf_q <= 1'b0;
      irq_cmp_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        bufie_q <= reg_wdata[C_BUFIE];
        cmpie_q <= reg_wdata[C_CMPIE];
      end
      rdata_q   <= (reg_addr == ADDR_CFG) ? cfg_view : stat_view;
      irq_buf_q <= bufie_q & buf_empty;
      irq_cmp_q <= cmpie_q & cmd_idle;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_buf   = irq_buf_q;
  assign irq_cmp   = irq_cmp_q;

  assert_irq_buf_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq_buf_q |-> $past(bufie_q && buf_empty));
  assert_irq_cmp_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq_cmp_q |-> $past(cmpie_q && cmd_idle));
  assert_hidden_results_R8: assert property (@(posedge clk) disable iff (rst)
    (!special_mode && reg_addr == ADDR_STAT) |=> (rdata_q[S_FAIL:S_DONE] == 2'b00));
endmodule

// File: tb/test_flash_cmd_stat.sv
`timescale 1ns/1ps
module test_flash_cmd_stat;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       special_mode = 1'b0;
  logic       reg_wr = 1'b0;
  logic [0:0] reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       flash_wr = 1'b0, prot_viol_in = 1'b0, acc_err_in = 1'b0;
  logic       eng_start, eng_done = 1'b0, eng_blank = 1'b0, eng_fail = 1'b0;
  logic       irq_buf, irq_cmp;
  int         total = 0;
  int         bad = 0;

  always #2 clk = ~clk;

  flash_cmd_stat i_flash_cmd_stat (
    .clk(clk), .rst(rst), .special_mode(special_mode), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flash_wr(flash_wr), .prot_viol_in(prot_viol_in), .acc_err_in(acc_err_in),
    .eng_start(eng_start), .eng_done(eng_done), .eng_blank(eng_blank),
    .eng_fail(eng_fail), .irq_buf(irq_buf), .irq_cmp(irq_cmp)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // expected status byte from flag values
  function automatic logic [7:0] stat_of(input logic b, c, pv, ae, bl, fl, dn);
    return {b, c, pv, ae, 1'b0, bl, fl, dn};
  endfunction

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_wr = 1'b0; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic open_seq();
    @(negedge clk); flash_wr = 1'b1;
    @(negedge clk); flash_wr = 1'b0;
  endtask

  task automatic finish_eng(input logic bl, input logic fl);
    @(negedge clk); eng_done = 1'b1; eng_blank = bl; eng_fail = fl;
    @(negedge clk); eng_done = 1'b0; eng_blank = 1'b0; eng_fail = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic pv_m, ae_m;
    int starts;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq_buf", irq_buf, 0);
    chk("R1 irq_cmp", irq_cmp, 0);
    rd(1'b0, v); chk("R1 status", v, 8'hC0);
    rd(1'b1, v); chk("R1 config", v, 8'h00);

    // R10 enables
    wr(1'b1, 8'hC0);
    @(negedge clk);
    chk("R10 irq_buf on", irq_buf, 1);
    chk("R10 irq_cmp on", irq_cmp, 1);
    rd(1'b1, v); chk("R10 config read", v, 8'hC0);

    // R4 write 0 to bit 7 outside a sequence
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R4 no access error", v, 8'hC0);

    // R2 launch with idle engine
    open_seq();
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h80;
    @(negedge clk); reg_wr = 1'b0;
    chk("R2 no start yet", eng_start, 0);
    @(negedge clk);
    chk("R2 start pulse", eng_start, 1);
    chk("R10 irq_cmp off while busy", irq_cmp, 0);
    @(negedge clk);
    chk("R2 single pulse", eng_start, 0);
    rd(1'b0, v); chk("R5 busy status", v, stat_of(1,0,0,0,0,0,0));

    // R5 second command buffered, then promoted
    open_seq();
    wr(1'b0, 8'h80);
    rd(1'b0, v); chk("R5 pending status", v, 8'h00);
    chk("R10 irq_buf off when full", irq_buf, 0);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    chk("R5 promotion start", eng_start, 1);
    rd(1'b0, v); chk("R5 complete stays low", v, stat_of(1,0,0,0,0,0,0));
    finish_eng(1'b1, 1'b0);
    rd(1'b0, v); chk("R11 blank captured R5 complete", v, stat_of(1,1,0,0,1,0,0));

    // R6 writes to read-only bits
    wr(1'b0, 8'h44);
    rd(1'b0, v); chk("R6 read-only bits", v, 8'hC4);

    // R3 abort
    open_seq();
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R3 access error", v, 8'hD4);
    starts = 0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h80;
    @(negedge clk); reg_wr = 1'b0;
    repeat (3) begin @(negedge clk); if (eng_start) starts++; end
    chk("R3 no launch after abort", starts, 0);
    wr(1'b0, 8'h10);
    rd(1'b0, v); chk("R7 clear access error", v, 8'hC4);

    // R7 same-cycle set and clear
    @(negedge clk); prot_viol_in = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h20;
    @(negedge clk); prot_viol_in = 1'b0; reg_wr = 1'b0;
    rd(1'b0, v); chk("R7 set wins", v, 8'hE4);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R7 w1c", v, 8'hC4);

    // R8 / R11 failing command in normal mode
    open_seq();
    wr(1'b0, 8'h80);
    repeat (2) @(negedge clk);
    rd(1'b0, v); chk("R11 blank cleared on start", v, 8'h80);
    finish_eng(1'b0, 1'b1);
    rd(1'b0, v); chk("R8 fail/done hidden", v, 8'hC0);
    wr(1'b0, 8'h03);

    // R9 special mode
    @(negedge clk); special_mode = 1'b1;
    rd(1'b0, v); chk("R8 write ignored R9 fail visible", v, stat_of(1,1,0,0,0,1,1));
    open_seq();
    rd(1'b0, v); chk("R9 fail blocks sequence", v, 8'hD3);
    starts = 0;
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h80;
    @(negedge clk); reg_wr = 1'b0;
    repeat (3) begin @(negedge clk); if (eng_start) starts++; end
    chk("R9 no launch with fail", starts, 0);
    wr(1'b0, 8'h12);
    rd(1'b0, v); chk("R9 fail cleared", v, 8'hC1);
    wr(1'b0, 8'h01);
    rd(1'b0, v); chk("R9 done read-only", v, 8'hC1);
    @(negedge clk); special_mode = 1'b0;

    // R10 disable
    wr(1'b1, 8'h00);
    @(negedge clk);
    chk("R10 irq_buf off", irq_buf, 0);
    chk("R10 irq_cmp off", irq_cmp, 0);

    // R7 random sets and clears
    pv_m = 1'b0; ae_m = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic sp, sa;
      logic [7:0] wd;
      logic w;
      sp = 1'($urandom); sa = 1'($urandom); w = 1'($urandom);
      wd = 8'($urandom) & 8'h7F;
      @(negedge clk);
      prot_viol_in = sp; acc_err_in = sa; reg_wr = w; reg_addr = 1'b0; reg_wdata = wd;
      @(negedge clk);
      prot_viol_in = 1'b0; acc_err_in = 1'b0; reg_wr = 1'b0;
      pv_m = sp | (pv_m & ~(w & wd[5]));
      ae_m = sa | (ae_m & ~(w & wd[4]));
      rd(1'b0, v);
      chk("R7 random", v, stat_of(1,1,pv_m,ae_m,0,0,0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule